// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the relative branches of a small 8-bit accumulator processor. For each instruction it receives the opcode byte, two operand bytes, the address of the instruction, the zero and carry flags, and the current index register value. It returns the address of the next instruction, whether the branch was taken, and how many clock cycles the instruction occupies. Flag-condition branches are decided from the flags alone. Bit-clear branches test one bit of a data byte, and the opcode selects which bit.

For a bit-clear branch the unit issues one read on a synchronous data-memory port. Two direct addresses are treated as special. One turns the read into an indexed read at the index register value. The other tests the index register itself, and no read is issued. Every other opcode is reported as unhandled, and the program counter is returned unchanged.

Instructions enter on a valid/ready handshake. `in_ready` is high only when the unit is idle. A source that raises `in_valid` must hold it, together with all instruction fields, until it sees `in_ready` high at a clock edge. The transfer takes place at that edge. After the transfer, `in_ready` stays low until the instruction's cycle count has elapsed. Results come out as a one-cycle `done` strobe and have no back-pressure.

Top module: `branch_resolver`

## Requirements
- R1: `in_ready` is high while idle. An instruction is accepted at a rising edge where `in_valid` and `in_ready` are both high; call that edge A and the cycle before it cycle 1. For an N-cycle instruction, `in_ready` is low in cycles 2 to N and high again in cycle N+1.
- R2: `done` is high for exactly cycle N+1 of each accepted instruction. It is registered at edge A+N-1, and `cycles` equals N in that cycle.
- R3: Opcode 0x30 is always taken, with next PC = PC + 2 + sign-extended operand 0. With an offset of 0 the next PC is PC + 2.
- R4: Opcode 0x34 is taken when C = 0 and opcode 0x35 is taken when C = 1. The target is PC + 2 + sign-extended operand 0; otherwise the next PC is PC + 2.
- R5: Opcode 0x36 is taken when Z = 0, with the same target and fall-through rules as R4.
- R6: The flag-condition branches (0x30, 0x34, 0x35, 0x36) take N = 3 and issue no memory read.
- R7: An opcode with bits [7:4] = 0 and bit 0 = 1 is a bit-clear branch. It tests bit number opcode[3:1] of the data byte and is taken when that bit is 0. The taken target is PC + 3 + sign-extended operand 1; otherwise the next PC is PC + 3. N = 5.
- R8: A bit-clear branch whose operand 0 is neither 0x0E nor 0x0F raises `mem_rd_en` for cycle 2 only, with `mem_rd_addr` = operand 0. The byte on `mem_rd_data` is sampled once, at the edge that ends cycle 3.
- R9: When operand 0 is 0x0E, the read of R8 goes to address `in_idx`.
- R10: When operand 0 is 0x0F, no read is issued, and the bit is tested in `in_idx` as captured at acceptance.
- R11: All next-PC arithmetic wraps modulo 2^14.
- R12: Any other opcode gives `unhandled` = 1, `taken` = 0, `next_pc` = PC and `cycles` = 1, with `done` in cycle 2 and no read.
- R13: During reset, `in_ready` = 1 and `done`, `mem_rd_en` and `unhandled` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction fields are valid |
| in_ready | output | 1 | Unit idle, can accept an instruction |
| in_opcode | input | 8 | Opcode byte |
| in_opnd0 | input | 8 | First operand byte (offset or direct address) |
| in_opnd1 | input | 8 | Second operand byte (offset of bit-clear branch) |
| in_pc | input | 14 | Address of the instruction |
| in_flag_z | input | 1 | Zero flag |
| in_flag_c | input | 1 | Carry flag |
| in_idx | input | 8 | Current index register value |
| mem_rd_en | output | 1 | Data-memory read strobe |
| mem_rd_addr | output | 8 | Data-memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the strobe |
| done | output | 1 | Result strobe |
| next_pc | output | 14 | Resolved next instruction address |
| taken | output | 1 | Branch was taken |
| cycles | output | 3 | Cycle count of the instruction |
| unhandled | output | 1 | Opcode is not a branch this unit resolves |

## Verification
A corrupted countdown shows first on `in_ready`, one cycle after the instruction is accepted, and then as a `done` strobe that arrives early, late or twice. The bench's per-clock reference model catches any of these in the cycle where it happens. A wrong stored offset, length or captured data byte stays hidden until the `done` cycle, where it shows as a wrong `next_pc` or `taken`. A bad read sequence shows at once as a misplaced or repeated `mem_rd_en` or a wrong `mem_rd_addr` in cycle 2.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {K_NONE, K_FLAG, K_BIT} kind_t;
  typedef enum logic [1:0] {S_DIRECT, S_INDEXED, S_REGISTER} src_t;

  localparam logic [7:0] IDX_PORT = 8'h0E;
  localparam logic [7:0] REG_PORT = 8'h0F;

  localparam int FLAG_CYC = 3;
  localparam int BIT_CYC  = 5;
  localparam int NONE_CYC = 1;
  localparam int FLAG_LEN = 2;
  localparam int BIT_LEN  = 3;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
#(
  parameter int CYC_W = 3
) (
  input  logic [7:0]       opcode,
  input  logic [7:0]       opnd0,
  input  logic [7:0]       opnd1,
  input  logic             flag_z,
  input  logic             flag_c,
  output kind_t            kind,
  output logic [CYC_W-1:0] n_cyc,
  output logic [1:0]       len,
  output logic [7:0]       rel,
  output logic             cond_take,
  output logic [2:0]       bit_sel,
  output src_t             src
);
  always_comb begin
    kind      = K_NONE;
    n_cyc     = CYC_W'(NONE_CYC);
    len       = 2'd0;
    rel       = opnd0;
    cond_take = 1'b0;
    bit_sel   = opcode[3:1];
    src       = S_DIRECT;
    unique case (opcode)
      8'h30, 8'h34, 8'h35, 8'h36: begin
        kind  = K_FLAG;
        n_cyc = CYC_W'(FLAG_CYC);
        len   = 2'(FLAG_LEN);
        unique case (opcode[2:0])
          3'd4:    cond_take = ~flag_c;
          3'd5:    cond_take = flag_c;
          3'd6:    cond_take = ~flag_z;
          default: cond_take = 1'b1;
        endcase
      end
      default: begin
        if (opcode[7:4] == 4'h0 && opcode[0]) begin
          kind  = K_BIT;
          n_cyc = CYC_W'(BIT_CYC);
          len   = 2'(BIT_LEN);
          rel   = opnd1;
          if (opnd0 == REG_PORT)      src = S_REGISTER;
          else if (opnd0 == IDX_PORT) src = S_INDEXED;
          else                        src = S_DIRECT;
        end
      end
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W = 14
) (
  input  logic [PC_W-1:0] base,
  input  logic [1:0]      len,
  input  logic [7:0]      rel,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] jump_pc
);
  localparam int EXT_W = PC_W - 8;

  logic [PC_W-1:0] rel_ext;

  assign rel_ext = {{EXT_W{rel[7]}}, rel};
  assign seq_pc  = base + PC_W'(len);
  assign jump_pc = seq_pc + rel_ext;
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver
  import br_pkg::*;
#(
  parameter int PC_W  = 14,
  parameter int CYC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_opcode,
  input  logic [7:0]       in_opnd0,
  input  logic [7:0]       in_opnd1,
  input  logic [PC_W-1:0]  in_pc,
  input  logic             in_flag_z,
  input  logic             in_flag_c,
  input  logic [7:0]       in_idx,
  output logic             mem_rd_en,
  output logic [7:0]       mem_rd_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             done,
  output logic [PC_W-1:0]  next_pc,
  output logic             taken,
  output logic [CYC_W-1:0] cycles,
  output logic             unhandled
);
  // remaining count at which the read data is on mem_rd_data
  localparam logic [CYC_W-1:0] SAMPLE_REM = CYC_W'(BIT_CYC - 2);

  kind_t            d_kind;
  logic [CYC_W-1:0] d_ncyc;
  logic [1:0]       d_len;
  logic [7:0]       d_rel;
  logic             d_take;
  logic [2:0]       d_bit;
  src_t             d_src;

  br_decode #(.CYC_W(CYC_W)) u_decode (
    .opcode    (in_opcode),
    .opnd0     (in_opnd0),
    .opnd1     (in_opnd1),
    .flag_z    (in_flag_z),
    .flag_c    (in_flag_c),
    .kind      (d_kind),
    .n_cyc     (d_ncyc),
    .len       (d_len),
    .rel       (d_rel),
    .cond_take (d_take),
    .bit_sel   (d_bit),
    .src       (d_src)
  );

  logic [CYC_W-1:0] rem;
  logic [CYC_W-1:0] r_ncyc;
  logic [PC_W-1:0]  r_pc;
  logic [1:0]       r_len;
  logic [7:0]       r_rel;
  kind_t            r_kind;
  logic             r_take;
  logic [2:0]       r_bit;
  src_t             r_src;
  logic [7:0]       r_byte;

  logic [PC_W-1:0]  seq_pc;
  logic [PC_W-1:0]  jump_pc;
  logic             fin_take;
  logic             accept;

  br_target #(.PC_W(PC_W)) u_target (
    .base    (r_pc),
    .len     (r_len),
    .rel     (r_rel),
    .seq_pc  (seq_pc),
    .jump_pc (jump_pc)
  );

  assign in_ready = (rem == '0);
  assign accept   = in_valid && in_ready;

  always_comb begin
    unique case (r_kind)
      K_FLAG:  fin_take = r_take;
      K_BIT:   fin_take = ~r_byte[r_bit];
      default: fin_take = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem         <= '0;
      r_ncyc      <= '0;
      r_pc        <= '0;
      r_len       <= '0;
      r_rel       <= '0;
      r_kind      <= K_NONE;
      r_take      <= 1'b0;
      r_bit       <= '0;
      r_src       <= S_DIRECT;
      r_byte      <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      next_pc     <= '0;
      taken       <= 1'b0;
      cycles      <= '0;
      unhandled   <= 1'b0;
    end else begin
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      if (accept) begin
        rem    <= d_ncyc - 1'b1;
        r_ncyc <= d_ncyc;
        r_pc   <= in_pc;
        r_len  <= d_len;
        r_rel  <= d_rel;
        r_kind <= d_kind;
        r_take <= d_take;
        r_bit  <= d_bit;
        r_src  <= d_src;
        if (d_kind == K_NONE) begin
          done      <= 1'b1;
          next_pc   <= in_pc;
          taken     <= 1'b0;
          cycles    <= d_ncyc;
          unhandled <= 1'b1;
        end
        if (d_kind == K_BIT) begin
          if (d_src == S_REGISTER) begin
            r_byte <= in_idx;
          end else begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= (d_src == S_INDEXED) ? in_idx : in_opnd0;
          end
        end
      end else if (rem != '0) begin
        rem <= rem - 1'b1;
        if (r_kind == K_BIT && r_src != S_REGISTER && rem == SAMPLE_REM)
          r_byte <= mem_rd_data;
        if (rem == CYC_W'(1)) begin
          done      <= 1'b1;
          next_pc   <= fin_take ? jump_pc : seq_pc;
          taken     <= fin_take;
          cycles    <= r_ncyc;
          unhandled <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/br_resolver_chk.sv
module br_resolver_chk #(
  parameter int CYC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [7:0]       in_opcode,
  input logic             mem_rd_en,
  input logic             done,
  input logic             taken,
  input logic [CYC_W-1:0] cycles,
  input logic             unhandled
);
  logic known;
  assign known = (in_opcode == 8'h30) || (in_opcode == 8'h34) ||
                 (in_opcode == 8'h35) || (in_opcode == 8'h36) ||
                 (in_opcode[7:4] == 4'h0 && in_opcode[0]);

  assert_busy_after_branch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && known) |=> !in_ready);

  assert_unhandled_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !known) |=> (done && unhandled));

  assert_unhandled_result_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && unhandled) |-> (cycles == CYC_W'(1) && !taken));

  assert_branch_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !unhandled) |-> (cycles == CYC_W'(3) || cycles == CYC_W'(5)));

  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_read_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> !in_ready);
endmodule

bind branch_resolver br_resolver_chk #(.CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_opcode (in_opcode),
  .mem_rd_en (mem_rd_en),
  .done      (done),
  .taken     (taken),
  .cycles    (cycles),
  .unhandled (unhandled)
);

// File: tb/branch_resolver_bench.sv
module branch_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = '0, in_opnd0 = '0, in_opnd1 = '0, in_idx = '0;
  logic [13:0] in_pc = '0;
  logic        in_flag_z = 1'b0, in_flag_c = 1'b0;
  logic        mem_rd_en;
  logic [7:0]  mem_rd_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        done, taken, unhandled;
  logic [13:0] next_pc;
  logic [2:0]  cycles;

  always #5 clk = ~clk;

  branch_resolver u_branch_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_opnd0(in_opnd0), .in_opnd1(in_opnd1),
    .in_pc(in_pc), .in_flag_z(in_flag_z), .in_flag_c(in_flag_c), .in_idx(in_idx),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .done(done), .next_pc(next_pc), .taken(taken), .cycles(cycles),
    .unhandled(unhandled)
  );

  int checks = 0, fails = 0;
  int cyc = 0, free_at = 0;
  int q_due[$], q_pc[$], q_tk[$], q_n[$], q_un[$];
  string q_tag[$];
  int rd_due = -1, rd_addr_x = 0;
  string rd_tag = "R8";
  bit acc_now = 0;
  string cur_tag = "";

  function automatic int memf(int a);
    return (a * 73 + 29) % 256;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference model, advanced on every rising edge
  always @(posedge clk) begin
    int e, op, pc, n, tk, tgt, a, b, r;
    e = cyc + 1;
    cyc = e;
    acc_now = 0;
    if (rst_n && in_valid && (e - 1 >= free_at)) begin
      acc_now = 1;
      op = int'(in_opcode);
      pc = int'(in_pc);
      if (op == 'h30 || op == 'h34 || op == 'h35 || op == 'h36) begin
        n = 3;
        r = int'($signed(in_opnd0));
        tk = (op == 'h30) ? 1 : (op == 'h34) ? !in_flag_c :
             (op == 'h35) ? in_flag_c : !in_flag_z;
        tgt = (pc + 2 + (tk ? r : 0)) & 'h3FFF;
        q_un.push_back(0);
      end else if ((op >> 4) == 0 && (op & 1) == 1) begin
        n = 5;
        a = int'(in_opnd0);
        b = (a == 'h0F) ? int'(in_idx) : memf((a == 'h0E) ? int'(in_idx) : a);
        tk = ((b >> ((op >> 1) & 7)) & 1) == 0;
        r = int'($signed(in_opnd1));
        tgt = (pc + 3 + (tk ? r : 0)) & 'h3FFF;
        if (a != 'h0F) begin
          rd_due = e;
          rd_addr_x = (a == 'h0E) ? int'(in_idx) : a;
          rd_tag = (a == 'h0E) ? "R9" : "R8";
        end
        q_un.push_back(0);
      end else begin
        n = 1; tk = 0; tgt = pc;
        q_un.push_back(1);
      end
      free_at = e + n - 1;
      q_due.push_back(e + n - 1);
      q_pc.push_back(tgt);
      q_tk.push_back(tk);
      q_n.push_back(n);
      q_tag.push_back(cur_tag);
    end
  end

  // synchronous data memory
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= 8'(memf(int'(mem_rd_addr)));

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    bit ed, er;
    if (!rst_n) begin
      chk(in_ready === 1'b1, "R13", "in_ready in reset", int'(in_ready), 1);
      chk(done === 1'b0, "R13", "done in reset", int'(done), 0);
      chk(mem_rd_en === 1'b0, "R13", "mem_rd_en in reset", int'(mem_rd_en), 0);
      chk(unhandled === 1'b0, "R13", "unhandled in reset", int'(unhandled), 0);
    end else begin
      chk(in_ready === (cyc >= free_at), "R1", "in_ready", int'(in_ready), int'(cyc >= free_at));
      ed = (q_due.size() > 0) && (q_due[0] == cyc);
      chk(done === ed, "R2", "done", int'(done), int'(ed));
      if (ed) begin
        chk(next_pc === 14'(q_pc[0]), q_tag[0], "next_pc", int'(next_pc), q_pc[0]);
        chk(taken === 1'(q_tk[0]), q_tag[0], "taken", int'(taken), q_tk[0]);
        chk(cycles === 3'(q_n[0]), q_tag[0], "cycles", int'(cycles), q_n[0]);
        chk(unhandled === 1'(q_un[0]), q_tag[0], "unhandled", int'(unhandled), q_un[0]);
        void'(q_due.pop_front()); void'(q_pc.pop_front()); void'(q_tk.pop_front());
        void'(q_n.pop_front()); void'(q_un.pop_front()); void'(q_tag.pop_front());
      end
      er = (rd_due == cyc);
      chk(mem_rd_en === er, "R8", "mem_rd_en", int'(mem_rd_en), int'(er));
      if (er) chk(mem_rd_addr === 8'(rd_addr_x), rd_tag, "mem_rd_addr", int'(mem_rd_addr), rd_addr_x);
    end
  end

  task automatic issue(input logic [7:0] op, input logic [7:0] o0, input logic [7:0] o1,
                       input int pc, input bit z, input bit c, input logic [7:0] idx,
                       input string tag);
    @(negedge clk);
    in_opcode = op; in_opnd0 = o0; in_opnd1 = o1; in_pc = 14'(pc);
    in_flag_z = z; in_flag_c = c; in_idx = idx; cur_tag = tag;
    in_valid = 1'b1;
    do begin
      @(posedge clk);
      #1;
    end while (!acc_now);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] unk [6] = '{8'h00, 8'h10, 8'h31, 8'h3F, 8'hFF, 8'h11};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    // R3 always-branch, forward / zero / backward with wrap (R11)
    issue(8'h30, 8'h05, 8'h00, 100, 0, 0, 0, "R3 R6");
    issue(8'h30, 8'h00, 8'h00, 200, 1, 1, 0, "R3 R6");
    issue(8'h30, 8'h80, 8'h00, 10, 0, 0, 0, "R3 R11");
    issue(8'h30, 8'h7F, 8'h00, 'h3FFE, 0, 0, 0, "R3 R11");
    idle(1);
    // R4 carry conditions
    issue(8'h34, 8'h10, 8'h00, 300, 0, 0, 0, "R4 R6");
    issue(8'h34, 8'h10, 8'h00, 300, 0, 1, 0, "R4 R6");
    issue(8'h35, 8'hF0, 8'h00, 400, 0, 1, 0, "R4 R6");
    issue(8'h35, 8'hF0, 8'h00, 400, 0, 0, 0, "R4 R6");
    // R5 zero condition
    issue(8'h36, 8'h22, 8'h00, 500, 0, 1, 0, "R5 R6");
    issue(8'h36, 8'h22, 8'h00, 500, 1, 0, 0, "R5 R6");
    idle(2);
    // R7 R8 direct bit tests on every bit number
    for (int b = 0; b < 8; b++)
      issue(8'((b << 1) | 1), 8'(16 + b * 3), 8'hFC, 600 + b, 0, 0, 0, "R7 R8");
    // R9 indexed, R10 register form
    issue(8'h01, 8'h0E, 8'h08, 700, 0, 0, 8'h44, "R9");
    issue(8'h0B, 8'h0E, 8'h08, 700, 0, 0, 8'h91, "R9");
    issue(8'h05, 8'h0F, 8'h40, 800, 0, 0, 8'hFB, "R10");
    issue(8'h05, 8'h0F, 8'h40, 800, 0, 0, 8'h04, "R10");
    issue(8'h0F, 8'h0F, 8'h80, 3, 0, 0, 8'h7F, "R10 R11");
    idle(1);
    // R12 unhandled opcodes, back to back
    for (int i = 0; i < 6; i++) issue(unk[i], 8'h12, 8'h34, 900 + i, 0, 0, 0, "R12");
    idle(3);
    // mixed random stream
    for (int i = 0; i < 300; i++) begin
      int k;
      logic [7:0] op, o0;
      k = int'($urandom % 8);
      if (k < 4)      op = (k == 0) ? 8'h30 : 8'(8'h33 + k);
      else if (k < 7) op = 8'(($urandom % 8) * 2 + 1);
      else            op = unk[$urandom % 6];
      o0 = 8'($urandom);
      if ($urandom % 4 == 0) o0 = ($urandom % 2) ? 8'h0E : 8'h0F;
      issue(op, o0, 8'($urandom), int'($urandom % 16384), 1'($urandom), 1'($urandom),
            8'($urandom), "R11 mixed");
      if ($urandom % 3 == 0) idle(int'($urandom % 3));
    end
    idle(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule